// File: doc/BRIEF.md
# Address Parity Checker with Delayed Sticky Error Flag

This block sits on the memory side of an address bus that carries an even-parity bit. On every read or write command it counts the ones across the address and the parity bit. If the count is odd, the address is corrupt. A corrupt write is stopped by dropping the write-allow output in the same cycle. A corrupt read still goes ahead; the block only records the error.

Each detected error travels down a short shift pipeline. After a programmable latency of 0 to 7 clock edges it sets a sticky flag. The flag drives an active-low error pin. The pin stays low until a clear strobe arrives from configuration logic. If a clear and a new error reach the flag on the same edge, the new error wins.

Checking can be turned off with an enable input. No-operation cycles and configuration-register cycles are never checked.

Top module: `addr_parity_guard`

## Requirements
- R1: A parity error is detected when the command is read or write, checking is enabled, and the number of ones in `{addr_i, par_i}` is odd. Command encodings on `cmd_i` are: 2'b00 no-op, 2'b01 read, 2'b10 write, 2'b11 configuration.
- R2: `wr_allow_o` is combinational. It is 1 exactly when `cmd_i` is write and no error is detected in that same cycle. A write with an error gives 0.
- R3: A read with an error leaves `wr_allow_o` at 0 and still raises the error flag. The read itself is not blocked.
- R4: Let E be the clock edge that samples an error, and let `rl_i` (0..7) be held stable. Then `err_n_o` reads 0 right after edge E+`rl_i`, and the error has no effect on `err_n_o` before that edge.
- R5: Once `err_n_o` is 0, it stays 0 on every later edge where `clr_i` is 0.
- R6: An edge with `clr_i` high and no error arriving from the latency pipeline returns `err_n_o` to 1. If an error arrives on the same edge, `err_n_o` stays 0.
- R7: With `chk_en_i` at 0, nothing is detected. Writes are allowed and `err_n_o` is unaffected.
- R8: No-op and configuration cycles are not checked, even with bad parity. They never raise the flag, and `wr_allow_o` is 0 during them.
- R9: While `rst_n` is low, the flag and the latency pipeline are cleared, so `err_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Command address |
| par_i | input | 1 | Even-parity bit for the address |
| cmd_i | input | 2 | Command type (no-op, read, write, configuration) |
| chk_en_i | input | 1 | Parity checking enable |
| rl_i | input | RL_W | Error-pin latency in clock edges |
| clr_i | input | 1 | Clear strobe for the sticky flag |
| wr_allow_o | output | 1 | Write may proceed to the array |
| err_n_o | output | 1 | Active-low sticky parity error |

## Verification
`wr_allow_o` is due in the same cycle as the command. The bench drives inputs on the falling edge and samples the output one time unit later, before the next rising edge.

`err_n_o` changes only on a rising edge, `rl_i` edges after the one that samples the error. The bench model keeps its own history of detected errors, steps it on each rising edge, and compares the pin one time unit after that edge. Every cycle of the lead-up is therefore checked as well as the falling edge of the flag.

Directed cases fix latencies 0 and 7 and the clear-versus-set collision. Random phases run each latency with mixed commands, error injection and clears.

// File: rtl/apg_pkg.sv
package apg_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_RD  = 2'b01,
    CMD_WR  = 2'b10,
    CMD_CFG = 2'b11
  } apg_cmd_e;

  // A command is subject to parity checking only for array accesses.
  function automatic logic cmd_is_checked(input logic [1:0] cmd);
    return (cmd == CMD_RD) || (cmd == CMD_WR);
  endfunction

endpackage

// File: rtl/apg_parity_chk.sv
module apg_parity_chk
  import apg_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              par_i,
  input  logic [1:0]        cmd_i,
  input  logic              chk_en_i,
  output logic              odd_o,
  output logic              det_o
);

  localparam int VEC_W = ADDR_W + 1;

  // Counts ones and reports whether the count is odd.
  function automatic logic ones_odd(input logic [VEC_W-1:0] v);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < VEC_W; i++) acc = acc ^ v[i];
    return acc;
  endfunction

  always_comb begin
    odd_o = ones_odd({addr_i, par_i});
    det_o = chk_en_i && cmd_is_checked(cmd_i) && odd_o;
  end

endmodule

// File: rtl/apg_delay_line.sv
module apg_delay_line #(
  parameter int RL_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            det_i,
  input  logic [RL_W-1:0] rl_i,
  output logic            tap_o
);

  localparam int DEPTH = (1 << RL_W) - 1;
  localparam int NTAP  = DEPTH + 1;

  logic [DEPTH-1:0] stage_q;
  logic [NTAP-1:0]  cand;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else if (DEPTH > 1) stage_q <= {stage_q[DEPTH-2:0], det_i};
    else stage_q <= {det_i};
  end

  // Tap 0 is the live detection; tap k is delayed by k edges.
  assign cand[0] = det_i;
  for (genvar k = 1; k < NTAP; k++) begin : g_tap
    assign cand[k] = stage_q[k-1];
  end

  assign tap_o = cand[rl_i];

endmodule

// File: rtl/apg_sticky_flag.sv
module apg_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

endmodule

// File: rtl/addr_parity_guard.sv
module addr_parity_guard
  import apg_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int RL_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              par_i,
  input  logic [1:0]        cmd_i,
  input  logic              chk_en_i,
  input  logic [RL_W-1:0]   rl_i,
  input  logic              clr_i,
  output logic              wr_allow_o,
  output logic              err_n_o
);

  logic odd_w;
  logic det_w;
  logic tap_w;
  logic flag_w;

  apg_parity_chk #(.ADDR_W(ADDR_W)) u_par (
    .addr_i   (addr_i),
    .par_i    (par_i),
    .cmd_i    (cmd_i),
    .chk_en_i (chk_en_i),
    .odd_o    (odd_w),
    .det_o    (det_w)
  );

  apg_delay_line #(.RL_W(RL_W)) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .det_i (det_w),
    .rl_i  (rl_i),
    .tap_o (tap_w)
  );

  apg_sticky_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (tap_w),
    .clr_i  (clr_i),
    .flag_o (flag_w)
  );

  assign wr_allow_o = (cmd_i == CMD_WR) && !det_w;
  assign err_n_o    = !flag_w;

endmodule

// File: rtl/apg_checker.sv
module apg_checker
  import apg_pkg::*;
#(
  parameter int RL_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      cmd_i,
  input logic            chk_en_i,
  input logic [RL_W-1:0] rl_i,
  input logic            clr_i,
  input logic            odd_w,
  input logic            det_w,
  input logic            tap_w,
  input logic            wr_allow_o,
  input logic            err_n_o
);

  // R1: an enabled, checked command with odd ones must be detected
  a_r1_detect: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en_i && odd_w && cmd_is_checked(cmd_i)) |-> det_w);

  // R2: a corrupt write never reaches the array
  a_r2_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_WR && det_w) |-> !wr_allow_o);

  // R3: write-allow only ever accompanies a write command
  a_r3_allow_only_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_allow_o |-> (cmd_i == CMD_WR));

  // R4: zero latency sets the flag on the detecting edge
  a_r4_rl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (det_w && rl_i == '0) |=> !err_n_o);

  // R5: the flag holds without a clear
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_n_o && !clr_i) |=> !err_n_o);

  // R6: clear releases the pin unless an error lands on the same edge
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !tap_w) |=> err_n_o);
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    tap_w |=> !err_n_o);

  // R7: disabled checking detects nothing
  a_r7_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en_i |-> !det_w);

  // R8: no-op and configuration cycles are never checked
  a_r8_unchecked: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_NOP || cmd_i == CMD_CFG) |-> (!det_w && !wr_allow_o));

endmodule

bind addr_parity_guard apg_checker #(.RL_W(RL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_i      (cmd_i),
  .chk_en_i   (chk_en_i),
  .rl_i       (rl_i),
  .clr_i      (clr_i),
  .odd_w      (odd_w),
  .det_w      (det_w),
  .tap_w      (tap_w),
  .wr_allow_o (wr_allow_o),
  .err_n_o    (err_n_o)
);

// File: tb/addr_parity_guard_bench.sv
`timescale 1ns/1ps
module addr_parity_guard_bench;

  localparam int AW = 21;
  localparam int RW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          par = 1'b0;
  logic [1:0]    cmd = 2'b00;
  logic          en = 1'b0;
  logic [RW-1:0] rl = '0;
  logic          clr = 1'b0;
  logic          wr_allow;
  logic          err_n;

  int checks = 0;
  int errors = 0;
  logic [7:0] hist = '0;  // model: past detections, bit 0 = one edge ago
  logic       mflag = 1'b0;

  always #5 clk = ~clk;

  addr_parity_guard u_addr_parity_guard (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .par_i(par), .cmd_i(cmd),
    .chk_en_i(en), .rl_i(rl), .clr_i(clr), .wr_allow_o(wr_allow), .err_n_o(err_n)
  );

  // Expected detection per R1/R7/R8
  function automatic logic exp_det(input logic [AW-1:0] a, input logic p,
                                   input logic [1:0] c, input logic e);
    int ones;
    ones = p;
    for (int i = 0; i < AW; i++) ones += a[i];
    return e && (c == 2'b01 || c == 2'b10) && (ones % 2 == 1);
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, check combinational output, step model, check flag.
  task automatic step(input logic [1:0] c, input logic bad, input logic e,
                      input logic cl, input string tag);
    logic d, tap;
    @(negedge clk);
    addr = AW'($urandom);
    par  = (^addr) ^ bad;
    cmd  = c; en = e; clr = cl;
    #1;
    d = exp_det(addr, par, cmd, en);
    check({tag, " R2 wr_allow"}, wr_allow, (cmd == 2'b10) && !d);
    @(posedge clk);
    tap = (rl == 0) ? d : hist[rl-1];
    hist = {hist[6:0], d};
    if (tap) mflag = 1'b1;
    else if (cl) mflag = 1'b0;
    #1;
    check({tag, " R4/R5/R6 err_n"}, err_n, !mflag);
  endtask

  task automatic drain();
    for (int i = 0; i < 9; i++) step(2'b00, 1'b0, 1'b1, 1'b0, "drain");
    for (int i = 0; i < 2; i++) step(2'b00, 1'b0, 1'b1, 1'b1, "drain R6 clear");
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset err_n", err_n, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;

    // R4: zero latency
    rl = 3'd0;
    step(2'b10, 1'b1, 1'b1, 1'b0, "R4 rl0 bad write R2");
    check("R4 rl0 flag low", err_n, 1'b0);
    drain();

    // R4: latency 7, flag must wait exactly seven edges
    rl = 3'd7;
    step(2'b01, 1'b1, 1'b1, 1'b0, "R3 bad read");
    for (int i = 1; i < 7; i++) begin
      step(2'b00, 1'b0, 1'b1, 1'b0, "R4 rl7 wait");
      check("R4 rl7 not yet", err_n, 1'b1);
    end
    step(2'b00, 1'b0, 1'b1, 1'b0, "R4 rl7 land");
    check("R4 rl7 landed", err_n, 1'b0);
    step(2'b00, 1'b0, 1'b1, 1'b0, "R5 hold");
    check("R5 sticky", err_n, 1'b0);
    drain();

    // R6: clear coinciding with an arriving error
    rl = 3'd2;
    step(2'b10, 1'b1, 1'b1, 1'b0, "R6 seed");
    step(2'b00, 1'b0, 1'b1, 1'b0, "R6 gap");
    step(2'b00, 1'b0, 1'b1, 1'b1, "R6 collide");
    check("R6 set wins", err_n, 1'b0);
    step(2'b00, 1'b0, 1'b1, 1'b1, "R6 clear");
    check("R6 cleared", err_n, 1'b1);

    // R7 and R8: bad parity that must be ignored
    step(2'b10, 1'b1, 1'b0, 1'b0, "R7 disabled write");
    step(2'b11, 1'b1, 1'b1, 1'b0, "R8 cfg");
    step(2'b00, 1'b1, 1'b1, 1'b0, "R8 nop");
    for (int i = 0; i < 8; i++) step(2'b00, 1'b0, 1'b1, 1'b0, "R7/R8 idle");
    check("R7/R8 no flag", err_n, 1'b1);

    // Random phases per latency, R1 through R8
    for (int r = 0; r < 8; r++) begin
      rl = 3'(r);
      for (int i = 0; i < 300; i++)
        step(2'($urandom), ($urandom % 6) == 0, ($urandom % 8) != 0,
             ($urandom % 10) == 0, "R1 random");
      drain();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule